// File: doc/BRIEF.md
# Version-Array Page Allocation Engine

This block carries out one privileged command: turning a free page of a protected page pool into an empty version-array page. A command is presented with a start pulse. It carries a command code, a page-type operand and the byte address of the target page. The engine first runs a fixed, prioritised series of checks on the command. If any check fails, it reports a general-protection fault, a page fault or a guest exit, and it changes nothing.

When every check passes, the engine locks the page against other page-management operations. It then writes the whole 4 KiB page to zero as consecutive 64-bit words through a valid/ready memory write port. After that it initialises the page's metadata entry and reports success with a one-cycle done pulse.

Other page-management operations are not modelled. They appear only as holders of the per-page lock, through an acquire/release port. A read port exposes any metadata entry.

Top module: `va_page_alloc`

## Requirements
- R1: A start pulse whose command code is not 0x0A is ignored: no done pulse, no memory write, and the engine stays ready for the next command.
- R2: If the type operand differs from 0x03 or the target address has any of its low 12 bits set, the result is status 1 (general-protection fault) with fault_info 0. This check has priority over all other checks, including the pool check.
- R3: An aligned target outside the pool range [POOL_BASE, POOL_BASE + 64*4096) gives status 2 (page fault), with fault_info equal to the target address.
- R4: If the target page is held by another operation and guest_mode and pool_virt_en are both 1, the result is status 3 (guest exit) with exit_reason 1, exit_qual 1, exit_err 0 and exit_gla equal to the target address. If the page is held and either of those inputs is 0, the result is status 1 with fault_info 0.
- R5: A target whose metadata entry is already valid gives status 2 with fault_info equal to the target address. No memory write is issued and the entry is unchanged.
- R6: On success the page is cleared by exactly 512 writes of zero data, at addresses target, target+8, ... target+4088 in that order. While ready is low, the write address is held.
- R7: After success the entry read on md_rd_data (one cycle after md_rd_idx is set) has valid=1 at bit 47, type=0x03 at bits 46:39, owner=0 at bits 38:7, blocked/pending/modified/PR=0 at bits 6:3, and read/write/execute=0 at bits 2:0.
- R8: done is a one-cycle pulse. On success, done rises on the second clock edge after the edge that accepts the last write; the metadata update happens on the edge in between. Status is 0.
- R9: While the engine holds a page, an external acquire of that page is refused (lk_gnt 0, one cycle after the request). Acquires of other pages are granted. After done, the page can be acquired again.
- R10: After reset, done and mem_wr_valid are 0, no page is locked, and every metadata entry reads as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command start pulse, sampled while idle |
| cmd_code | input | 32 | Command code; only 0x0A is accepted |
| type_op | input | 8 | Page-type operand; must be 0x03 |
| target_addr | input | ADDR_W | Byte address of the target page |
| guest_mode | input | 1 | Command issued from guest mode |
| pool_virt_en | input | 1 | Pool-virtualisation extension enabled |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Byte address of the word being written |
| mem_wr_data | output | WORD_W | Write data (always zero) |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 general fault, 2 page fault, 3 guest exit; valid with done |
| fault_info | output | ADDR_W | Page-fault address, 0 for general faults |
| exit_reason | output | 16 | Guest exit reason |
| exit_qual | output | 8 | Guest exit qualification code |
| exit_err | output | 8 | Guest exit error field |
| exit_gla | output | ADDR_W | Guest linear address of the exit |
| lk_acq | input | 1 | External lock acquire request |
| lk_rel | input | 1 | External lock release |
| lk_idx | input | IDX_W | Page index for acquire/release |
| lk_gnt | output | 1 | Acquire granted (registered) |
| md_rd_idx | input | IDX_W | Metadata read index |
| md_rd_data | output | META_W | Metadata entry read data (registered) |

## Verification
The bench targets these corner cases, and what a wrong design would do in each:
- Check ordering: a misaligned address that is also outside the pool must give a general fault. Testing the pool first would give a page fault instead.
- Pool boundaries: the first address past the pool and the last page inside it are both tested, which exposes off-by-one range and index arithmetic.
- Held page: the guest exit must appear only when both guest inputs are high, and a lock acquire must be refused while the engine is mid-clear. A swapped condition or a missing engine hold would let both owners proceed.
- Repeat command: re-running on the same page must give a page fault with no write at all. A design that overwrites a valid entry or clears before checking would show extra writes.

// File: rtl/va_pkg.sv
package va_pkg;
  localparam int VA_ADDR_W = 32;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_GP   = 2'd1,
    ST_PF   = 2'd2,
    ST_EXIT = 2'd3
  } va_status_e;

  localparam logic [31:0] LEAF_ADD_VA       = 32'h0000_000A;
  localparam logic [7:0]  VA_PAGE_TYPE      = 8'h03;
  localparam logic [15:0] EXIT_RSN_CONFLICT = 16'd1;
  localparam logic [7:0]  QUAL_PAGE_BUSY    = 8'd1;

  typedef struct packed {
    logic                 valid;
    logic [7:0]           ptype;
    logic [VA_ADDR_W-1:0] owner;
    logic                 blocked;
    logic                 pending;
    logic                 modified;
    logic                 pr;
    logic [2:0]           rwx;
  } va_meta_t;
endpackage

// File: rtl/va_lock_table.sv
module va_lock_table #(
  parameter int NUM_PAGES = 64,
  localparam int IDX_W = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acq,
  input  logic             rel,
  input  logic [IDX_W-1:0] idx,
  output logic             gnt,
  input  logic             eng_set,
  input  logic             eng_clr,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [IDX_W-1:0] chk_idx,
  output logic             chk_held
);
  logic [NUM_PAGES-1:0] ext_lock;
  logic                 eng_hold;
  logic [IDX_W-1:0]     eng_idx_q;
  logic                 req_held;

  assign chk_held = ext_lock[chk_idx] | (eng_hold && eng_idx_q == chk_idx);
  // engine wins a same-cycle race for a page
  assign req_held = ext_lock[idx] | (eng_hold && eng_idx_q == idx) |
                    (eng_set && eng_idx == idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_lock  <= '0;
      eng_hold  <= 1'b0;
      eng_idx_q <= '0;
      gnt       <= 1'b0;
    end else begin
      gnt <= acq && !req_held;
      if (acq && !req_held) ext_lock[idx] <= 1'b1;
      else if (rel)         ext_lock[idx] <= 1'b0;
      if (eng_set) begin
        eng_hold  <= 1'b1;
        eng_idx_q <= eng_idx;
      end else if (eng_clr) begin
        eng_hold <= 1'b0;
      end
    end
  end

  // R9
  engine_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (acq && eng_hold && eng_idx_q == idx) |=> !gnt);
endmodule

// File: rtl/va_meta_table.sv
module va_meta_table
  import va_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  localparam int IDX_W = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] chk_idx,
  output logic             chk_valid,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  va_meta_t         wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output va_meta_t         rd_data
);
  logic [NUM_PAGES-1:0] valid_q;
  va_meta_t             body [NUM_PAGES];
  va_meta_t             body_rd;
  logic                 valid_rd;

  assign chk_valid = valid_q[chk_idx];

  // entry bodies: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en) body[wr_idx] <= wr_data;
    body_rd <= body[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      valid_rd <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      valid_rd <= valid_q[rd_idx];
    end
  end

  assign rd_data = valid_rd ? body_rd : '0;

  // R5
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !valid_q[wr_idx]);
endmodule

// File: rtl/va_page_alloc.sv
module va_page_alloc
  import va_pkg::*;
#(
  parameter int          NUM_PAGES  = 64,
  parameter int          PAGE_BYTES = 4096,
  parameter int          WORD_W     = 64,
  parameter logic [31:0] POOL_BASE  = 32'h0010_0000,
  localparam int ADDR_W = VA_ADDR_W,
  localparam int IDX_W  = $clog2(NUM_PAGES),
  localparam int META_W = $bits(va_meta_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       cmd_code,
  input  logic [7:0]        type_op,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic              guest_mode,
  input  logic              pool_virt_en,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] fault_info,
  output logic [15:0]       exit_reason,
  output logic [7:0]        exit_qual,
  output logic [7:0]        exit_err,
  output logic [ADDR_W-1:0] exit_gla,
  input  logic              lk_acq,
  input  logic              lk_rel,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_gnt,
  input  logic [IDX_W-1:0]  md_rd_idx,
  output logic [META_W-1:0] md_rd_data
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int NUM_WORDS  = PAGE_BYTES / WORD_BYTES;
  localparam int CNT_W      = $clog2(NUM_WORDS);
  localparam int PAGE_SH    = $clog2(PAGE_BYTES);
  localparam int BYTE_SH    = $clog2(WORD_BYTES);
  localparam logic [ADDR_W:0] POOL_END =
    {1'b0, POOL_BASE} + (ADDR_W+1)'(NUM_PAGES * PAGE_BYTES);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(NUM_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_CLEAR, S_META, S_FIN} state_e;
  state_e state;

  logic [7:0]        op_type;
  logic [ADDR_W-1:0] op_addr;
  logic              op_guest, op_virt;
  logic [CNT_W-1:0]  cnt;

  logic              aligned, type_ok, in_pool, held, slot_valid, pass;
  logic [ADDR_W-1:0] pool_off;
  logic [IDX_W-1:0]  page_idx;
  va_meta_t          fresh, rd_entry;

  assign aligned    = op_addr[PAGE_SH-1:0] == '0;
  assign type_ok    = op_type == VA_PAGE_TYPE;
  assign in_pool    = ({1'b0, op_addr} >= {1'b0, POOL_BASE}) && ({1'b0, op_addr} < POOL_END);
  assign pool_off   = op_addr - POOL_BASE;
  assign page_idx   = pool_off[PAGE_SH +: IDX_W];
  assign pass       = aligned && type_ok && in_pool && !held && !slot_valid;

  always_comb begin
    fresh       = '0;
    fresh.valid = 1'b1;
    fresh.ptype = VA_PAGE_TYPE;
  end

  va_lock_table #(.NUM_PAGES(NUM_PAGES)) i_locks (
    .clk(clk), .rst(rst), .acq(lk_acq), .rel(lk_rel), .idx(lk_idx), .gnt(lk_gnt),
    .eng_set(state == S_CHECK && pass), .eng_clr(state == S_META),
    .eng_idx(page_idx), .chk_idx(page_idx), .chk_held(held)
  );

  va_meta_table #(.NUM_PAGES(NUM_PAGES)) i_meta (
    .clk(clk), .rst(rst), .chk_idx(page_idx), .chk_valid(slot_valid),
    .wr_en(state == S_META), .wr_idx(page_idx), .wr_data(fresh),
    .rd_idx(md_rd_idx), .rd_data(rd_entry)
  );

  assign md_rd_data   = rd_entry;
  assign mem_wr_valid = state == S_CLEAR;
  assign mem_wr_addr  = op_addr + ADDR_W'({cnt, {BYTE_SH{1'b0}}});
  assign mem_wr_data  = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      done        <= 1'b0;
      status      <= ST_OK;
      fault_info  <= '0;
      exit_reason <= '0;
      exit_qual   <= '0;
      exit_err    <= '0;
      exit_gla    <= '0;
      op_type     <= '0;
      op_addr     <= '0;
      op_guest    <= 1'b0;
      op_virt     <= 1'b0;
      cnt         <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start && cmd_code == LEAF_ADD_VA) begin
          op_type  <= type_op;
          op_addr  <= target_addr;
          op_guest <= guest_mode;
          op_virt  <= pool_virt_en;
          state    <= S_CHECK;
        end
        S_CHECK: begin
          fault_info  <= '0;
          exit_reason <= '0;
          exit_qual   <= '0;
          exit_err    <= '0;
          exit_gla    <= '0;
          cnt         <= '0;
          if (pass) begin
            state <= S_CLEAR;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
            if (!aligned || !type_ok) begin
              status <= ST_GP;
            end else if (!in_pool) begin
              status     <= ST_PF;
              fault_info <= op_addr;
            end else if (held) begin
              if (op_guest && op_virt) begin
                status      <= ST_EXIT;
                exit_reason <= EXIT_RSN_CONFLICT;
                exit_qual   <= QUAL_PAGE_BUSY;
                exit_gla    <= op_addr;
              end else begin
                status <= ST_GP;
              end
            end else begin
              status     <= ST_PF;
              fault_info <= op_addr;
            end
          end
        end
        S_CLEAR: if (mem_wr_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_WORD) state <= S_META;
        end
        S_META: state <= S_FIN;
        S_FIN: begin
          done   <= 1'b1;
          status <= ST_OK;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_after_meta_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status == ST_OK) |-> $past(state == S_META, 2));
  // R1
  bad_leaf_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && cmd_code != LEAF_ADD_VA) |=> state == S_IDLE);
  // R2
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status != ST_OK) |=> !mem_wr_valid);
endmodule

// File: tb/test_va_page_alloc.sv
`timescale 1ns/1ps
module test_va_page_alloc;
  import va_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cmd_code = '0;
  logic [7:0]  type_op = '0;
  logic [31:0] target_addr = '0;
  logic        guest_mode = 1'b0, pool_virt_en = 1'b0;
  logic        mem_wr_valid, mem_wr_ready = 1'b1;
  logic [31:0] mem_wr_addr;
  logic [63:0] mem_wr_data;
  logic        done;
  logic [1:0]  status;
  logic [31:0] fault_info, exit_gla;
  logic [15:0] exit_reason;
  logic [7:0]  exit_qual, exit_err;
  logic        lk_acq = 1'b0, lk_rel = 1'b0, lk_gnt;
  logic [5:0]  lk_idx = '0, md_rd_idx = '0;
  logic [47:0] md_rd_data;

  va_page_alloc i_va_page_alloc (
    .clk(clk), .rst(rst), .start(start), .cmd_code(cmd_code), .type_op(type_op),
    .target_addr(target_addr), .guest_mode(guest_mode), .pool_virt_en(pool_virt_en),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .done(done), .status(status), .fault_info(fault_info),
    .exit_reason(exit_reason), .exit_qual(exit_qual), .exit_err(exit_err),
    .exit_gla(exit_gla), .lk_acq(lk_acq), .lk_rel(lk_rel), .lk_idx(lk_idx),
    .lk_gnt(lk_gnt), .md_rd_idx(md_rd_idx), .md_rd_data(md_rd_data)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nerr = 0;
  int cyc = 0, last_acc = 0, done_cyc = 0;
  int wr_total = 0, wr_k = 0, wr_bad = 0;
  logic [31:0] exp_base = '0;
  logic rdy_toggle = 1'b0;
  logic [1:0]  got_st;
  logic [31:0] got_info, got_gla;
  logic [15:0] got_rsn;
  logic [7:0]  got_qual, got_err;

  localparam logic [47:0] VA_ENTRY = {1'b1, 8'h03, 32'h0, 7'h0};

  typedef struct packed {
    logic [7:0]  ptype;
    logic [31:0] addr;
    logic [1:0]  exp_st;
    logic [31:0] exp_info;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h03, 32'h0010_0800, 2'd1, 32'h0},          // R2 misaligned
    '{8'h05, 32'h0010_1000, 2'd1, 32'h0},          // R2 wrong type
    '{8'h03, 32'h0014_0000, 2'd2, 32'h0014_0000},  // R3 first past end
    '{8'h03, 32'h000F_F000, 2'd2, 32'h000F_F000},  // R3 below pool
    '{8'h03, 32'h0020_0004, 2'd1, 32'h0},          // R2 priority over pool
    '{8'h07, 32'h0030_0000, 2'd1, 32'h0}           // R2 priority over pool
  };

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_wr_valid && mem_wr_ready) begin
      if (mem_wr_addr !== exp_base + 32'(wr_k * 8) || mem_wr_data !== 64'h0) wr_bad++;
      wr_k++;
      wr_total++;
      last_acc = cyc;
    end
  end

  always @(negedge clk) if (rdy_toggle) mem_wr_ready <= ~mem_wr_ready;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] c, input logic [7:0] t, input logic [31:0] a,
                       input logic g, input logic v);
    @(negedge clk);
    cmd_code = c; type_op = t; target_addr = a; guest_mode = g; pool_virt_en = v;
    exp_base = a; wr_k = 0; wr_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    got_st = status; got_info = fault_info; got_gla = exit_gla;
    got_rsn = exit_reason; got_qual = exit_qual; got_err = exit_err;
    done_cyc = cyc;
  endtask

  task automatic read_md(input logic [5:0] i, output logic [47:0] d);
    @(negedge clk);
    md_rd_idx = i;
    @(negedge clk);
    d = md_rd_data;
  endtask

  task automatic lock_req(input logic [5:0] i, output logic g);
    @(negedge clk);
    lk_idx = i; lk_acq = 1'b1;
    @(negedge clk);
    lk_acq = 1'b0;
    g = lk_gnt;
  endtask

  task automatic lock_rel(input logic [5:0] i);
    @(negedge clk);
    lk_idx = i; lk_rel = 1'b1;
    @(negedge clk);
    lk_rel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [47:0] md;
    logic g;
    int w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 done after reset", done, 0);
    chk("R10 mem_wr_valid after reset", mem_wr_valid, 0);
    read_md(6'd2, md);
    chk("R10 entry invalid after reset", md[47], 0);

    // R1 unknown command ignored
    w0 = wr_total;
    issue(32'h0B, 8'h03, 32'h0010_3000, 0, 0);
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); if (done) seen++; end
      chk("R1 no done for bad code", seen, 0);
    end
    chk("R1 no writes for bad code", wr_total - w0, 0);

    // fault vector table (R2, R3)
    foreach (VECS[i]) begin
      w0 = wr_total;
      issue(32'h0A, VECS[i].ptype, VECS[i].addr, 0, 0);
      wait_done();
      chk($sformatf("R2/R3 vec%0d status", i), got_st, VECS[i].exp_st);
      chk($sformatf("R2/R3 vec%0d info", i), got_info, VECS[i].exp_info);
      chk($sformatf("R2/R3 vec%0d no writes", i), wr_total - w0, 0);
    end

    // R6 success on page 2 with initial stall, R9 lock behaviour
    mem_wr_ready = 1'b0;
    w0 = wr_total;
    issue(32'h0A, 8'h03, 32'h0010_2000, 0, 0);
    repeat (3) @(negedge clk);
    chk("R6 valid while stalled", mem_wr_valid, 1);
    chk("R6 first address", mem_wr_addr, 32'h0010_2000);
    lock_req(6'd2, g);
    chk("R9 held page refused", g, 0);
    lock_req(6'd9, g);
    chk("R9 other page granted", g, 1);
    lock_rel(6'd9);
    chk("R6 address held over stall", mem_wr_addr, 32'h0010_2000);
    mem_wr_ready = 1'b1;
    wait_done();
    chk("R8 success status", got_st, 0);
    chk("R6 write count", wr_total - w0, 512);
    chk("R6 write addr/data sequence", wr_bad, 0);
    chk("R8 done two edges after last write", done_cyc - last_acc, 2);
    @(negedge clk);
    chk("R8 done is a pulse", done, 0);
    read_md(6'd2, md);
    chk("R7 metadata entry", md, VA_ENTRY);
    lock_req(6'd2, g);
    chk("R9 page free after done", g, 1);
    lock_rel(6'd2);

    // R5 repeat on valid page
    w0 = wr_total;
    issue(32'h0A, 8'h03, 32'h0010_2000, 0, 0);
    wait_done();
    chk("R5 status on valid page", got_st, 2);
    chk("R5 fault address", got_info, 32'h0010_2000);
    chk("R5 no writes", wr_total - w0, 0);
    read_md(6'd2, md);
    chk("R5 entry unchanged", md, VA_ENTRY);

    // last page of the pool with toggling ready
    rdy_toggle = 1'b1;
    w0 = wr_total;
    issue(32'h0A, 8'h03, 32'h0013_F000, 0, 0);
    wait_done();
    rdy_toggle = 1'b0;
    @(negedge clk);
    mem_wr_ready = 1'b1;
    chk("R6 last page status", got_st, 0);
    chk("R6 last page count", wr_total - w0, 512);
    chk("R6 last page sequence", wr_bad, 0);
    chk("R8 done timing under toggling ready", done_cyc - last_acc, 2);
    read_md(6'd63, md);
    chk("R7 last page entry", md, VA_ENTRY);

    // R4 conflicts
    lock_req(6'd7, g);
    chk("R4 external lock taken", g, 1);
    issue(32'h0A, 8'h03, 32'h0010_7000, 1, 1);
    wait_done();
    chk("R4 exit status", got_st, 3);
    chk("R4 exit reason", got_rsn, 16'd1);
    chk("R4 exit qual", got_qual, 8'd1);
    chk("R4 exit err", got_err, 8'd0);
    chk("R4 exit gla", got_gla, 32'h0010_7000);
    issue(32'h0A, 8'h03, 32'h0010_7000, 1, 0);
    wait_done();
    chk("R4 guest without ext gives GP", got_st, 1);
    chk("R4 GP info", got_info, 0);
    issue(32'h0A, 8'h03, 32'h0010_7000, 0, 1);
    wait_done();
    chk("R4 host gives GP", got_st, 1);
    read_md(6'd7, md);
    chk("R4 entry untouched by conflict", md[47], 0);
    lock_rel(6'd7);
    issue(32'h0A, 8'h03, 32'h0010_7000, 0, 0);
    wait_done();
    chk("R4 success after release", got_st, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule